// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a small counter that takes two separate count strobes, one that steps the value up and one that steps it down, instead of a single clock with a direction bit. A parameter chooses between a decade range (0 to 9) and a full binary range (0 to 2^WIDTH-1). A clear input and an active-low load input override counting. A load copies a preset word into the count.

Two active-low terminal-count outputs flag the wrap points. The carry output marks the top of the range and the borrow output marks zero. Each one is low only during the low phase of its strobe, so its rising edge coincides with the wrap. Wiring carry and borrow to the up and down strobes of a further stage builds a wider counter.

The block runs on a free-running system clock. Both strobes pass through two-flop synchronizers and an edge detector. Clear and load are sampled synchronous levels, and clear has the higher priority. In decade mode, codes 10 to 15 that reach the count through a load rejoin the legal sequence within two counts.

Top module: `updn_dual_counter`

## Requirements
- R1: A rising edge of the up strobe increments the count by one, provided the down strobe is high when that edge is sampled.
- R2: A rising edge of the down strobe decrements the count by one, provided the up strobe is high when that edge is sampled.
- R3: While clear is high, the count becomes 0 on the next system clock and stays there. Clear wins over load and over both strobes.
- R4: While load_n is low and clear is low, the count takes the preset word on each system clock. It follows changes of the preset word, and strobe edges have no effect.
- R5: carry_n is 0 exactly when the count equals the maximum and the synchronized up strobe is low. Otherwise it is 1, so it returns to 1 on the up edge that wraps the count.
- R6: borrow_n is 0 exactly when the count is 0 and the synchronized down strobe is low. Otherwise it is 1, so it returns to 1 on the down edge that wraps the count.
- R7: The maximum is 9 with DECADE=1 and 2^WIDTH-1 with DECADE=0. Counting up from the maximum gives 0, and counting down from 0 gives the maximum.
- R8: With DECADE=1, a count step from an illegal code follows a fixed map. Counting up, 10 goes to 11, 12 to 13 and 14 to 15, and 11, 13 and 15 go to 0. Counting down, every code from 10 to 15 goes to 9.
- R9: If both strobes rise in the same sampled cycle, or one strobe rises while the other is low, the count holds its value.
- R10: Two decade stages cascade correctly when the first stage's carry_n drives the second stage's up strobe and its borrow_n drives the second stage's down strobe. Up from 09 reaches 10, and down from 10 reaches 09.
- R11: After system reset the count is 0 and both terminal-count outputs are 1, with both strobes idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low system reset |
| up_strobe_i | input | 1 | Count-up strobe; rising edge counts; idle high |
| dn_strobe_i | input | 1 | Count-down strobe; rising edge counts; idle high |
| clear_i | input | 1 | Active-high clear to zero; highest priority |
| load_n_i | input | 1 | Active-low load of the preset word |
| preset_i | input | WIDTH | Preset word |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low up terminal count |
| borrow_n_o | output | 1 | Active-low down terminal count |

## Verification
The bench builds one instance with DECADE=1 and one with DECADE=0, both WIDTH=4, and drives the same strobes to both. The two instances hit their maximum values of 9 and 15 on the same steps, so the wrap points and terminal-count pulses of both modes can be compared side by side. The decade instance can be loaded with codes 10 to 15, which brings the recovery map within reach. The binary instance shows that the same codes simply count on. A second pair of decade instances wired carry-to-up and borrow-to-down covers the ripple of a terminal-count edge into the next stage.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= {pipe_q[DEPTH-2:0], async_i};
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/updn_step_ctl.sv
module updn_step_ctl
  import updn_pkg::*;
(
  input  logic  up_level_i,
  input  logic  up_rise_i,
  input  logic  dn_level_i,
  input  logic  dn_rise_i,
  output step_e step_o
);
  always_comb begin
    step_o = STEP_HOLD;
    if (up_rise_i && !dn_rise_i && dn_level_i) begin
      step_o = STEP_UP;
    end else if (dn_rise_i && !up_rise_i && up_level_i) begin
      step_o = STEP_DOWN;
    end
  end
endmodule

// File: rtl/updn_next.sv
module updn_next
  import updn_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cur_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] MAXV = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic [WIDTH-1:0] up_val;
  logic [WIDTH-1:0] dn_val;

  generate
    if (DECADE) begin : g_decade
      always_comb begin
        if (cur_i == MAXV) begin
          up_val = '0;
        end else if (cur_i > MAXV) begin
          up_val = cur_i[0] ? '0 : cur_i + WIDTH'(1);
        end else begin
          up_val = cur_i + WIDTH'(1);
        end
        if (cur_i == '0 || cur_i > MAXV) begin
          dn_val = MAXV;
        end else begin
          dn_val = cur_i - WIDTH'(1);
        end
      end
    end else begin : g_binary
      assign up_val = cur_i + WIDTH'(1);
      assign dn_val = cur_i - WIDTH'(1);
    end
  endgenerate

  always_comb begin
    unique case (step_i)
      STEP_UP:   nxt_o = up_val;
      STEP_DOWN: nxt_o = dn_val;
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/updn_dual_counter.sv
module updn_dual_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_strobe_i,
  input  logic             dn_strobe_i,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam logic [WIDTH-1:0] MAXV = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] rise;

  assign raw_in = {dn_strobe_i, up_strobe_i};

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_sync
      updn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in[ch]),
        .level_o (lvl[ch]),
        .rise_o  (rise[ch])
      );
    end
  endgenerate

  step_e            step;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_nxt;

  updn_step_ctl u_ctl (
    .up_level_i (lvl[0]),
    .up_rise_i  (rise[0]),
    .dn_level_i (lvl[1]),
    .dn_rise_i  (rise[1]),
    .step_o     (step)
  );

  updn_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .cur_i  (count_q),
    .step_i (step),
    .nxt_o  (count_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (!load_n_i) begin
      count_q <= preset_i;
    end else begin
      count_q <= count_nxt;
    end
  end

  assign count_o    = count_q;
  assign carry_n_o  = ~((count_q == MAXV) && !lvl[0]);
  assign borrow_n_o = ~((count_q == '0) && !lvl[1]);

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0));

  a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !load_n_i) |=> (count_o == $past(preset_i)));

  a_r5_carry_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |-> (count_o == MAXV));

  a_r6_borrow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n_o |-> (count_o == '0));

  a_r9_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && rise[1] && !clear_i && load_n_i) |=> $stable(count_o));

  a_r8_down_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (DECADE && step == STEP_DOWN && count_o > MAXV && !clear_i && load_n_i)
      |=> (count_o == MAXV));
endmodule

// File: tb/test_updn_dual_counter.sv
`timescale 1ns/1ps
module test_updn_dual_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic up_s = 1'b1, dn_s = 1'b1, clr = 1'b0, ld_n = 1'b1;
  logic [3:0] pre_d = '0, pre_b = '0;
  logic [3:0] cnt_d, cnt_b;
  logic cy_d, bw_d, cy_b, bw_b;

  updn_dual_counter #(.WIDTH(4), .DECADE(1'b1)) i_updn_dual_counter (
    .clk(clk), .rst_n(rst_n), .up_strobe_i(up_s), .dn_strobe_i(dn_s),
    .clear_i(clr), .load_n_i(ld_n), .preset_i(pre_d),
    .count_o(cnt_d), .carry_n_o(cy_d), .borrow_n_o(bw_d));

  updn_dual_counter #(.WIDTH(4), .DECADE(1'b0)) i_bin (
    .clk(clk), .rst_n(rst_n), .up_strobe_i(up_s), .dn_strobe_i(dn_s),
    .clear_i(clr), .load_n_i(ld_n), .preset_i(pre_b),
    .count_o(cnt_b), .carry_n_o(cy_b), .borrow_n_o(bw_b));

  logic c_up = 1'b1, c_dn = 1'b1, c_ld_n = 1'b1;
  logic [3:0] c_pre0 = '0, c_pre1 = '0;
  logic [3:0] c_cnt0, c_cnt1;
  logic c_cy0, c_bw0, c_cy1, c_bw1;

  updn_dual_counter #(.WIDTH(4), .DECADE(1'b1)) i_casc0 (
    .clk(clk), .rst_n(rst_n), .up_strobe_i(c_up), .dn_strobe_i(c_dn),
    .clear_i(1'b0), .load_n_i(c_ld_n), .preset_i(c_pre0),
    .count_o(c_cnt0), .carry_n_o(c_cy0), .borrow_n_o(c_bw0));

  updn_dual_counter #(.WIDTH(4), .DECADE(1'b1)) i_casc1 (
    .clk(clk), .rst_n(rst_n), .up_strobe_i(c_cy0), .dn_strobe_i(c_bw0),
    .clear_i(1'b0), .load_n_i(c_ld_n), .preset_i(c_pre1),
    .count_o(c_cnt1), .carry_n_o(c_cy1), .borrow_n_o(c_bw1));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_up();
    up_s = 1'b0; tick(5); up_s = 1'b1; tick(5);
  endtask

  task automatic go_dn();
    dn_s = 1'b0; tick(5); dn_s = 1'b1; tick(5);
  endtask

  task automatic load_both(input logic [3:0] d, input logic [3:0] b);
    pre_d = d; pre_b = b; ld_n = 1'b0; tick(3); ld_n = 1'b1; tick(2);
  endtask

  task automatic t_reset();
    chk("R11 count dec", cnt_d, 0);
    chk("R11 count bin", cnt_b, 0);
    chk("R11 carry_n", cy_d, 1);
    chk("R11 borrow_n", bw_d, 1);
  endtask

  task automatic t_sequence();
    clr = 1'b1; tick(2); clr = 1'b0; tick(1);
    chk("R3 clear dec", cnt_d, 0);
    load_both(4'd7, 4'd13);
    chk("R4 preset dec", cnt_d, 7);
    chk("R4 preset bin", cnt_b, 13);
    go_up();
    chk("R1 up dec", cnt_d, 8);
    chk("R1 up bin", cnt_b, 14);
    go_up();
    chk("R1 up dec", cnt_d, 9);
    chk("R5 carry idle high", cy_d, 1);
    up_s = 1'b0; tick(5);
    chk("R5 carry low dec", cy_d, 0);
    chk("R5 carry low bin", cy_b, 0);
    up_s = 1'b1; tick(5);
    chk("R5 carry back high", cy_d, 1);
    chk("R7 wrap up dec", cnt_d, 0);
    chk("R7 wrap up bin", cnt_b, 0);
    go_up(); go_up();
    chk("R1 up dec", cnt_d, 2);
    go_dn();
    chk("R2 down dec", cnt_d, 1);
    go_dn();
    chk("R2 down dec", cnt_d, 0);
    chk("R6 borrow idle high", bw_d, 1);
    dn_s = 1'b0; tick(5);
    chk("R6 borrow low dec", bw_d, 0);
    chk("R6 borrow low bin", bw_b, 0);
    dn_s = 1'b1; tick(5);
    chk("R6 borrow back high", bw_d, 1);
    chk("R7 wrap down dec", cnt_d, 9);
    chk("R7 wrap down bin", cnt_b, 15);
    go_dn(); go_dn();
    chk("R2 down dec", cnt_d, 7);
    chk("R2 down bin", cnt_b, 13);
  endtask

  task automatic t_load_override();
    pre_d = 4'd3; pre_b = 4'd3; ld_n = 1'b0; tick(3);
    chk("R4 follow", cnt_d, 3);
    pre_d = 4'd5; tick(2);
    chk("R4 follow change", cnt_d, 5);
    go_up();
    chk("R4 strobe ignored", cnt_d, 5);
    clr = 1'b1; tick(2);
    chk("R3 clear beats load", cnt_d, 0);
    clr = 1'b0; ld_n = 1'b1; tick(2);
    clr = 1'b1; go_up(); clr = 1'b0; tick(1);
    chk("R3 clear beats strobe", cnt_d, 0);
  endtask

  task automatic t_conflict();
    load_both(4'd4, 4'd4);
    up_s = 1'b0; dn_s = 1'b0; tick(5);
    up_s = 1'b1; dn_s = 1'b1; tick(6);
    chk("R9 both rise hold", cnt_d, 4);
    chk("R9 both rise hold bin", cnt_b, 4);
    up_s = 1'b0; tick(3); dn_s = 1'b0; tick(3);
    up_s = 1'b1; tick(6);
    chk("R9 up while down low", cnt_d, 4);
    dn_s = 1'b1; tick(6);
    chk("R2 down after conflict", cnt_d, 3);
  endtask

  task automatic t_illegal();
    load_both(4'd10, 4'd10);
    go_up();
    chk("R8 up 10", cnt_d, 11);
    chk("R7 bin 10 up", cnt_b, 11);
    go_up();
    chk("R8 up 11", cnt_d, 0);
    chk("R7 bin 11 up", cnt_b, 12);
    load_both(4'd12, 4'd12);
    go_up();
    chk("R8 up 12", cnt_d, 13);
    go_up();
    chk("R8 up 13", cnt_d, 0);
    load_both(4'd14, 4'd14);
    go_up();
    chk("R8 up 14", cnt_d, 15);
    go_up();
    chk("R8 up 15", cnt_d, 0);
    for (int code = 10; code < 16; code++) begin
      load_both(4'(code), 4'(code));
      go_dn();
      chk("R8 down illegal", cnt_d, 9);
      chk("R7 bin down", cnt_b, code - 1);
    end
  endtask

  task automatic t_cascade();
    c_pre0 = 4'd8; c_pre1 = 4'd0; c_ld_n = 1'b0; tick(3); c_ld_n = 1'b1; tick(8);
    chk("R10 load lo", c_cnt0, 8);
    c_up = 1'b0; tick(5); c_up = 1'b1; tick(10);
    chk("R10 lo 9", c_cnt0, 9);
    chk("R10 hi 0", c_cnt1, 0);
    c_up = 1'b0; tick(5); c_up = 1'b1; tick(10);
    chk("R10 lo wrap", c_cnt0, 0);
    chk("R10 hi carry in", c_cnt1, 1);
    c_dn = 1'b0; tick(5); c_dn = 1'b1; tick(10);
    chk("R10 lo wrap down", c_cnt0, 9);
    chk("R10 hi borrow in", c_cnt1, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_sequence();
    t_load_override();
    t_conflict();
    t_illegal();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule